// File: doc/BRIEF.md
# Descriptor Chain Walker for One DMA Channel

This block runs one DMA channel's list of transfer descriptors kept in memory. Software writes the memory address of the first descriptor and then sets the channel's run bit. The block reads the descriptor as six 32-bit words over a read port that takes one request at a time. It parses the words into the fields a transfer engine needs and holds that descriptor on the engine interface until the engine signals completion. It then loads the next descriptor from the link word. The walk ends when the link word holds the end-of-list address.

Each finished descriptor produces a one-cycle package strobe. The last descriptor also produces a queue strobe in the same cycle. The address of the descriptor in use is always visible on an output. The bytes are moved by a separate engine, which is outside this block. A channel window of eight word registers gives software control and read-back. An outer decoder maps that window at 0x100 plus 0x40 per channel. A pause bit stops the walk at its next safe point: before a new fetch begins, or before the engine is started.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset the run bit reads 0. `mem_req`, `xfer_valid`, `pkg_done` and `queue_done` are low, and `cur_desc_addr` is 0.
- R2: The run bit (offset 0x00, bit 0) reads 1 from the write that sets it until the list ends. It then clears itself, in the same cycle as `queue_done`.
- R3: A descriptor is fetched as six reads, one outstanding at a time. The reads go to the descriptor address plus 0, 4, 8, 12, 16 and 20, and the words are, in order: config, source address, destination address, byte count, parameter and link. `mem_addr` stays stable while a request waits for `mem_rvalid`.
- R4: Every `xfer_done` received while `xfer_valid` is high gives one `pkg_done` pulse one cycle later. If the link word is not 0xFFFFF800, the block then fetches the descriptor at the link address.
- R5: When the link word of the finished descriptor is 0xFFFFF800, `queue_done` pulses once, in the same cycle as that descriptor's `pkg_done`, and the walk stops.
- R6: The config word is decoded in two halves: bits 15:0 give the source settings and bits 31:16 the destination settings. Within each half, the request line is bits 4:0, the address mode is bits 6:5, the width is bits 10:9 and the burst is two bits starting at parameter `BURST_LSB` (default 7). Address mode 1 sets the side's fixed-address output; any other mode clears it.
- R7: The parameter word gives the block size from bits 15:8 and the wait cycles from bits 7:0.
- R8: The window reads back the following registers: pause at 0x04 (bit 0), start address at 0x08, and the current descriptor's config at 0x0C, source at 0x10, destination at 0x14, byte count at 0x18 and parameter at 0x1C.
- R9: While pause is set, no new descriptor fetch begins. Clearing pause resumes the walk.
- R10: Setting pause during a fetch lets the remaining words of that fetch complete. The engine is not started (`xfer_valid` stays low) until pause clears.
- R11: Writing 0 to the run bit stops the walk at once, from any state. The run bit reads 0, no `queue_done` is raised, and a later start walks a fresh list normally.
- R12: Writing 1 to the run bit while the walk is active has no effect on the walk in progress.
- R13: `cur_desc_addr` holds the address of the descriptor being fetched or executed, and keeps the last descriptor's address after the list ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset within the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Descriptor presented to the engine |
| xfer_cfg | output | 32 | Raw config word |
| xfer_src_addr | output | 32 | Source address |
| xfer_dst_addr | output | 32 | Destination address |
| xfer_bcnt | output | 32 | Byte count |
| xfer_blk_size | output | 8 | Block size field |
| xfer_wait_cyc | output | 8 | Wait cycles field |
| xfer_src_drq | output | 5 | Source request line |
| xfer_dst_drq | output | 5 | Destination request line |
| xfer_src_fixed | output | 1 | Source address is fixed |
| xfer_dst_fixed | output | 1 | Destination address is fixed |
| xfer_src_burst | output | 2 | Source burst code |
| xfer_dst_burst | output | 2 | Destination burst code |
| xfer_src_width | output | 2 | Source width code |
| xfer_dst_width | output | 2 | Destination width code |
| xfer_done | input | 1 | Engine finished the presented descriptor |
| pkg_done | output | 1 | One-cycle strobe per finished descriptor |
| queue_done | output | 1 | One-cycle strobe when the list ends |
| cur_desc_addr | output | 32 | Address of the current descriptor |

## Verification
The bench checks that a three-entry list is walked in link order, with every fetched word landing in the correct field. A design that counted links, or stopped on a flag instead of the end-of-list address, would show a wrong strobe count or run past the list. Pause is applied both before the first fetch and in the middle of a fetch. A design that dropped an in-flight fetch would show fewer than six words read, and one that ignored pause would start the engine early. A halt written during a fetch must leave no queue strobe and no stale state behind, so that a restart walks the list cleanly. The bench also checks the half-swapped config decode and that a second run-bit write during a walk is ignored.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
    localparam int DW         = 32;
    localparam int DESC_WORDS = 6;
    localparam int WIDX_W     = $clog2(DESC_WORDS);
    localparam logic [DW-1:0] CHAIN_END = 32'hFFFF_F800;

    localparam int W_CFG  = 0;
    localparam int W_SRC  = 1;
    localparam int W_DST  = 2;
    localparam int W_BCNT = 3;
    localparam int W_PARA = 4;
    localparam int W_LINK = 5;

    localparam logic [5:0] OFS_RUN   = 6'h00;
    localparam logic [5:0] OFS_PAUSE = 6'h04;
    localparam logic [5:0] OFS_START = 6'h08;
    localparam logic [5:0] OFS_CFG   = 6'h0C;
    localparam logic [5:0] OFS_SRC   = 6'h10;
    localparam logic [5:0] OFS_DST   = 6'h14;
    localparam logic [5:0] OFS_BCNT  = 6'h18;
    localparam logic [5:0] OFS_PARA  = 6'h1C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FETCH,
        ST_READY,
        ST_RUN
    } walk_st_e;

    typedef struct packed {
        walk_st_e          st;
        logic [WIDX_W-1:0] idx;
        logic [DW-1:0]     cur;
        logic              pkg;
        logic              qd;
    } walk_t;

    localparam walk_t WALK_RST = '{st: ST_IDLE, idx: '0, cur: '0, pkg: 1'b0, qd: 1'b0};

    typedef struct packed {
        logic [4:0] drq;
        logic [1:0] amode;
        logic [1:0] burst;
        logic [1:0] width;
    } side_cfg_t;

    typedef struct packed {
        logic          pause;
        logic [DW-1:0] start;
    } ctl_t;
endpackage

// File: rtl/dmaw_desc_store.sv
module dmaw_desc_store
    import dmaw_pkg::*;
#(
    parameter int NWORDS = DESC_WORDS,
    localparam int IW    = $clog2(NWORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IW-1:0]             idx,
    input  logic [DW-1:0]             wdata,
    output logic [NWORDS-1:0][DW-1:0] words
);
    logic [NWORDS-1:0][DW-1:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        for (int i = 0; i < NWORDS; i++) begin
            if (we && (idx == IW'(i))) begin
                words_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign words = words_q;
endmodule

// File: rtl/dmaw_cfg_decode.sv
module dmaw_cfg_decode
    import dmaw_pkg::*;
#(
    parameter int BURST_LSB = 7
) (
    input  logic [DW-1:0] cfg,
    output side_cfg_t     src_side,
    output side_cfg_t     dst_side
);
    side_cfg_t sides [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [15:0] half;
        assign half = cfg[16*h +: 16];
        assign sides[h] = '{drq:   half[4:0],
                            amode: half[6:5],
                            burst: half[BURST_LSB+1:BURST_LSB],
                            width: half[10:9]};
    end

    assign src_side = sides[0];
    assign dst_side = sides[1];
endmodule

// File: rtl/dmaw_walker.sv
module dmaw_walker
    import dmaw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              halt_req,
    input  logic              pause,
    input  logic [DW-1:0]     start_addr,
    input  logic [DW-1:0]     link_ptr,
    input  logic              mem_rvalid,
    input  logic              xfer_done,
    output logic              busy,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    output logic              word_we,
    output logic [WIDX_W-1:0] word_idx,
    output logic              xfer_valid,
    output logic              pkg_done,
    output logic              queue_done,
    output logic [DW-1:0]     cur_addr
);
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(DESC_WORDS - 1);

    walk_t q, d;

    always_comb begin
        d     = q;
        d.pkg = 1'b0;
        d.qd  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_req) begin
                    d.cur = start_addr;
                    d.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!pause) begin
                    d.idx = '0;
                    d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_rvalid) begin
                    if (q.idx == LAST_IDX) d.st  = ST_READY;
                    else                   d.idx = q.idx + 1'b1;
                end
            end
            ST_READY: begin
                if (!pause) d.st = ST_RUN;
            end
            ST_RUN: begin
                if (xfer_done) begin
                    d.pkg = 1'b1;
                    if (link_ptr == CHAIN_END) begin
                        d.qd = 1'b1;
                        d.st = ST_IDLE;
                    end else begin
                        d.cur = link_ptr;
                        d.st  = ST_LOAD;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (halt_req) begin
            d.st  = ST_IDLE;
            d.pkg = 1'b0;
            d.qd  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= WALK_RST;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign mem_req    = (q.st == ST_FETCH);
    assign mem_addr   = q.cur + (DW'(q.idx) << 2);
    assign word_we    = mem_req && mem_rvalid;
    assign word_idx   = q.idx;
    assign xfer_valid = (q.st == ST_RUN);
    assign pkg_done   = q.pkg;
    assign queue_done = q.qd;
    assign cur_addr   = q.cur;
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dmaw_pkg::*;
#(
    parameter int BURST_LSB = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [5:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          xfer_valid,
    output logic [31:0]   xfer_cfg,
    output logic [31:0]   xfer_src_addr,
    output logic [31:0]   xfer_dst_addr,
    output logic [31:0]   xfer_bcnt,
    output logic [7:0]    xfer_blk_size,
    output logic [7:0]    xfer_wait_cyc,
    output logic [4:0]    xfer_src_drq,
    output logic [4:0]    xfer_dst_drq,
    output logic          xfer_src_fixed,
    output logic          xfer_dst_fixed,
    output logic [1:0]    xfer_src_burst,
    output logic [1:0]    xfer_dst_burst,
    output logic [1:0]    xfer_src_width,
    output logic [1:0]    xfer_dst_width,
    input  logic          xfer_done,
    output logic          pkg_done,
    output logic          queue_done,
    output logic [31:0]   cur_desc_addr
);
    localparam logic [1:0] AMODE_FIXED = 2'd1;

    ctl_t ctl_d, ctl_q;
    logic run_wr, start_req, halt_req, busy, paused;
    logic word_we;
    logic [WIDX_W-1:0] word_idx;
    logic [DESC_WORDS-1:0][DW-1:0] words;
    side_cfg_t src_side, dst_side;

    assign run_wr    = reg_we && (reg_addr == OFS_RUN);
    assign start_req = run_wr && reg_wdata[0] && !busy;
    assign halt_req  = run_wr && !reg_wdata[0];
    assign paused    = ctl_q.pause;

    always_comb begin
        ctl_d = ctl_q;
        if (reg_we && (reg_addr == OFS_PAUSE)) ctl_d.pause = reg_wdata[0];
        if (reg_we && (reg_addr == OFS_START)) ctl_d.start = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dmaw_walker u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .halt_req   (halt_req),
        .pause      (paused),
        .start_addr (ctl_q.start),
        .link_ptr   (words[W_LINK]),
        .mem_rvalid (mem_rvalid),
        .xfer_done  (xfer_done),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .word_we    (word_we),
        .word_idx   (word_idx),
        .xfer_valid (xfer_valid),
        .pkg_done   (pkg_done),
        .queue_done (queue_done),
        .cur_addr   (cur_desc_addr)
    );

    dmaw_desc_store #(.NWORDS(DESC_WORDS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (word_we),
        .idx   (word_idx),
        .wdata (mem_rdata),
        .words (words)
    );

    dmaw_cfg_decode #(.BURST_LSB(BURST_LSB)) u_decode (
        .cfg      (words[W_CFG]),
        .src_side (src_side),
        .dst_side (dst_side)
    );

    assign xfer_cfg       = words[W_CFG];
    assign xfer_src_addr  = words[W_SRC];
    assign xfer_dst_addr  = words[W_DST];
    assign xfer_bcnt      = words[W_BCNT];
    assign xfer_blk_size  = words[W_PARA][15:8];
    assign xfer_wait_cyc  = words[W_PARA][7:0];
    assign xfer_src_drq   = src_side.drq;
    assign xfer_dst_drq   = dst_side.drq;
    assign xfer_src_fixed = (src_side.amode == AMODE_FIXED);
    assign xfer_dst_fixed = (dst_side.amode == AMODE_FIXED);
    assign xfer_src_burst = src_side.burst;
    assign xfer_dst_burst = dst_side.burst;
    assign xfer_src_width = src_side.width;
    assign xfer_dst_width = dst_side.width;

    always_comb begin
        unique case (reg_addr)
            OFS_RUN:   reg_rdata = {31'b0, busy};
            OFS_PAUSE: reg_rdata = {31'b0, ctl_q.pause};
            OFS_START: reg_rdata = ctl_q.start;
            OFS_CFG:   reg_rdata = words[W_CFG];
            OFS_SRC:   reg_rdata = words[W_SRC];
            OFS_DST:   reg_rdata = words[W_DST];
            OFS_BCNT:  reg_rdata = words[W_BCNT];
            OFS_PARA:  reg_rdata = words[W_PARA];
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmaw_checker.sv
module dmaw_checker
    import dmaw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        paused,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        xfer_valid,
    input logic        xfer_done,
    input logic        pkg_done,
    input logic        queue_done
);
    logic halt_wr;
    assign halt_wr = reg_we && (reg_addr == OFS_RUN) && !reg_wdata[0];

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && !halt_wr) |=> (mem_req && $stable(mem_addr))); // R3
    AST_PKG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_done |-> $past(xfer_valid && xfer_done)); // R4
    AST_QD_WITH_PKG: assert property (@(posedge clk) disable iff (!rst_n)
        queue_done |-> pkg_done); // R5
    AST_QD_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        queue_done |-> !busy); // R2
    AST_NO_FETCH_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !mem_req) |=> !mem_req); // R9
    AST_XFER_UNPAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_valid) |-> $past(!paused)); // R10
    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wr |=> (!busy && !mem_req && !xfer_valid && !queue_done)); // R11
endmodule

bind dma_chain_walker dmaw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .paused     (paused),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .xfer_valid (xfer_valid),
    .xfer_done  (xfer_done),
    .pkg_done   (pkg_done),
    .queue_done (queue_done)
);

// File: tb/tb_dma_chain_walker.sv
module tb_dma_chain_walker;
    localparam logic [31:0] EOL = 32'hFFFF_F800;
    localparam int MEM_LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        xfer_valid;
    logic [31:0] xfer_cfg, xfer_src_addr, xfer_dst_addr, xfer_bcnt;
    logic [7:0]  xfer_blk_size, xfer_wait_cyc;
    logic [4:0]  xfer_src_drq, xfer_dst_drq;
    logic        xfer_src_fixed, xfer_dst_fixed;
    logic [1:0]  xfer_src_burst, xfer_dst_burst, xfer_src_width, xfer_dst_width;
    logic        xfer_done = 1'b0;
    logic        pkg_done, queue_done;
    logic [31:0] cur_desc_addr;

    dma_chain_walker dut (.*);

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [31:0] mem [0:255];
    int words_fetched = 0;
    int lat_cnt = 0;
    int eng_lat = 3;
    int eng_cnt = 0;
    int xfer_seen = 0;
    logic [31:0] log_src [0:63];
    logic [31:0] log_bcnt [0:63];
    logic [31:0] log_cur [0:63];
    int pkg_cnt = 0, qd_cnt = 0, qd_alone = 0, req_cycles = 0;

    // memory model: one outstanding request, fixed latency
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
        end else if (mem_req) begin
            if (lat_cnt >= MEM_LAT) begin
                mem_rdata     = mem[mem_addr[9:2]];
                mem_rvalid    = 1'b1;
                lat_cnt       = 0;
                words_fetched = words_fetched + 1;
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // transfer engine model
    always @(negedge clk) begin
        if (xfer_done) begin
            xfer_done = 1'b0;
        end else if (xfer_valid) begin
            if (eng_cnt == 0) begin
                log_src[xfer_seen % 64]  = xfer_src_addr;
                log_bcnt[xfer_seen % 64] = xfer_bcnt;
                log_cur[xfer_seen % 64]  = cur_desc_addr;
            end
            eng_cnt = eng_cnt + 1;
            if (eng_cnt >= eng_lat) begin
                xfer_done = 1'b1;
                eng_cnt   = 0;
                xfer_seen = xfer_seen + 1;
            end
        end else begin
            eng_cnt = 0;
        end
    end

    always @(posedge clk) begin
        #1;
        if (pkg_done) pkg_cnt++;
        if (queue_done) qd_cnt++;
        if (queue_done && !pkg_done) qd_alone++;
        if (mem_req) req_cycles++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_desc(input int a, input logic [31:0] cfg, src, dst, bcnt, para, link);
        mem[(a >> 2) + 0] = cfg;
        mem[(a >> 2) + 1] = src;
        mem[(a >> 2) + 2] = dst;
        mem[(a >> 2) + 3] = bcnt;
        mem[(a >> 2) + 4] = para;
        mem[(a >> 2) + 5] = link;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        v = 32'd1;
        while (v[0] && n < 3000) begin
            rd(6'h00, v);
            n++;
        end
        chk(!v[0], req, v, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(6'h00, v);
        chk(v == 0, "R1 run bit", v, 0);
        chk(!mem_req && !xfer_valid && !pkg_done && !queue_done, "R1 outputs idle",
            {mem_req, xfer_valid, pkg_done, queue_done}, 0);
        chk(cur_desc_addr == 0, "R1 cur_desc_addr", cur_desc_addr, 0);
    endtask

    task automatic t_chain3;
        int p0, q0, a0, w0, x0;
        logic [31:0] v;
        put_desc('h40, 32'h0, 32'h1000, 32'h2000, 32'd16, 32'h0, 32'h80);
        put_desc('h80, 32'h0, 32'h1100, 32'h2100, 32'd32, 32'h0, 32'hC0);
        put_desc('hC0, 32'h0, 32'h1200, 32'h2200, 32'd48, 32'h0, EOL);
        p0 = pkg_cnt; q0 = qd_cnt; a0 = qd_alone; w0 = words_fetched; x0 = xfer_seen;
        eng_lat = 3;
        wr(6'h08, 32'h40);
        wr(6'h00, 32'h1);
        rd(6'h00, v);
        chk(v[0] == 1'b1, "R2 run bit reads 1 while active", v, 1);
        wait_idle("R2 run bit self-clears");
        repeat (2) @(negedge clk);
        chk(words_fetched - w0 == 18, "R3 six words per descriptor", words_fetched - w0, 18);
        chk(log_src[x0 % 64] == 32'h1000 && log_src[(x0+1) % 64] == 32'h1100 &&
            log_src[(x0+2) % 64] == 32'h1200, "R3 source words in link order", log_src[(x0+2) % 64], 32'h1200);
        chk(log_bcnt[(x0+1) % 64] == 32'd32, "R3 byte count word", log_bcnt[(x0+1) % 64], 32);
        chk(pkg_cnt - p0 == 3, "R4 one pkg_done per descriptor", pkg_cnt - p0, 3);
        chk(qd_cnt - q0 == 1, "R5 single queue_done", qd_cnt - q0, 1);
        chk(qd_alone == a0, "R5 queue_done with last pkg_done", qd_alone - a0, 0);
        chk(log_cur[x0 % 64] == 32'h40 && log_cur[(x0+1) % 64] == 32'h80,
            "R13 cur_desc_addr during execution", log_cur[(x0+1) % 64], 32'h80);
        chk(cur_desc_addr == 32'hC0, "R13 cur_desc_addr after end", cur_desc_addr, 32'hC0);
    endtask

    task automatic t_decode;
        int p0, w0;
        int n;
        logic [31:0] v;
        // src half: drq 17, mode 1, burst 1, width 1; dst half: drq 1, mode 0, burst 2, width 2
        put_desc('h100, 32'h0501_02B1, 32'hA000_0010, 32'hB000_0020, 32'd64, 32'h0000_2A07, EOL);
        p0 = pkg_cnt; w0 = words_fetched;
        eng_lat = 60;
        wr(6'h08, 32'h100);
        wr(6'h00, 32'h1);
        n = 0;
        while (!xfer_valid && n < 500) begin @(negedge clk); n++; end
        chk(xfer_src_drq == 5'd17 && xfer_dst_drq == 5'd1, "R6 request lines",
            {xfer_src_drq, xfer_dst_drq}, {5'd17, 5'd1});
        chk(xfer_src_fixed && !xfer_dst_fixed, "R6 address mode fixed flags",
            {xfer_src_fixed, xfer_dst_fixed}, 2'b10);
        chk(xfer_src_burst == 2'd1 && xfer_dst_burst == 2'd2 && xfer_src_width == 2'd1 &&
            xfer_dst_width == 2'd2, "R6 burst and width",
            {xfer_src_burst, xfer_dst_burst, xfer_src_width, xfer_dst_width}, 8'b01100110);
        chk(xfer_blk_size == 8'h2A && xfer_wait_cyc == 8'h07, "R7 parameter fields",
            {xfer_blk_size, xfer_wait_cyc}, 16'h2A07);
        rd(6'h0C, v); chk(v == 32'h0501_02B1, "R8 config readback", v, 32'h0501_02B1);
        rd(6'h10, v); chk(v == 32'hA000_0010, "R8 source readback", v, 32'hA000_0010);
        rd(6'h14, v); chk(v == 32'hB000_0020, "R8 destination readback", v, 32'hB000_0020);
        rd(6'h18, v); chk(v == 32'd64, "R8 byte count readback", v, 64);
        rd(6'h1C, v); chk(v == 32'h2A07, "R8 parameter readback", v, 32'h2A07);
        rd(6'h08, v); chk(v == 32'h100, "R8 start readback", v, 32'h100);
        wr(6'h08, 32'h40);
        wr(6'h00, 32'h1);
        wait_idle("R12 walk ends normally");
        repeat (2) @(negedge clk);
        chk(pkg_cnt - p0 == 1, "R12 second start ignored (pkg count)", pkg_cnt - p0, 1);
        chk(words_fetched - w0 == 6, "R12 second start ignored (fetches)", words_fetched - w0, 6);
        chk(cur_desc_addr == 32'h100, "R12 cur_desc_addr kept", cur_desc_addr, 32'h100);
        eng_lat = 3;
    endtask

    task automatic t_pause_pre;
        int p0, q0, r0;
        logic [31:0] v;
        put_desc('h180, 32'h0, 32'h3000, 32'h4000, 32'd8, 32'h0, 32'h1C0);
        put_desc('h1C0, 32'h0, 32'h3100, 32'h4100, 32'd8, 32'h0, EOL);
        wr(6'h04, 32'h1);
        p0 = pkg_cnt; q0 = qd_cnt; r0 = req_cycles;
        wr(6'h08, 32'h180);
        wr(6'h00, 32'h1);
        repeat (30) @(negedge clk);
        chk(req_cycles == r0, "R9 no fetch while paused", req_cycles - r0, 0);
        rd(6'h00, v);
        chk(v[0] == 1'b1, "R9 run bit held while paused", v, 1);
        rd(6'h04, v);
        chk(v[0] == 1'b1, "R8 pause readback", v, 1);
        wr(6'h04, 32'h0);
        wait_idle("R9 resumes after unpause");
        repeat (2) @(negedge clk);
        chk(pkg_cnt - p0 == 2 && qd_cnt - q0 == 1, "R9 list completes",
            pkg_cnt - p0, 2);
    endtask

    task automatic t_pause_mid;
        int p0, w0, x0, n;
        put_desc('h200, 32'h0, 32'h5000, 32'h6000, 32'd4, 32'h0, 32'h240);
        put_desc('h240, 32'h0, 32'h5100, 32'h6100, 32'd4, 32'h0, EOL);
        p0 = pkg_cnt; w0 = words_fetched; x0 = xfer_seen;
        wr(6'h08, 32'h200);
        wr(6'h00, 32'h1);
        n = 0;
        while (!mem_req && n < 100) begin @(negedge clk); n++; end
        wr(6'h04, 32'h1);
        repeat (40) @(negedge clk);
        chk(words_fetched - w0 == 6, "R10 in-flight fetch completes", words_fetched - w0, 6);
        chk(xfer_seen == x0 && !xfer_valid, "R10 engine not started while paused",
            xfer_seen - x0, 0);
        chk(pkg_cnt == p0, "R10 no package while paused", pkg_cnt - p0, 0);
        wr(6'h04, 32'h0);
        wait_idle("R10 resumes");
        repeat (2) @(negedge clk);
        chk(pkg_cnt - p0 == 2, "R10 both descriptors run", pkg_cnt - p0, 2);
    endtask

    task automatic t_halt;
        int p0, q0, x0, n;
        logic [31:0] v;
        put_desc('h280, 32'h0, 32'h7000, 32'h8000, 32'd4, 32'h0, 32'h2C0);
        put_desc('h2C0, 32'h0, 32'h7100, 32'h8100, 32'd4, 32'h0, EOL);
        p0 = pkg_cnt; q0 = qd_cnt; x0 = xfer_seen;
        wr(6'h08, 32'h280);
        wr(6'h00, 32'h1);
        n = 0;
        while (!mem_req && n < 100) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        wr(6'h00, 32'h0);
        repeat (40) @(negedge clk);
        rd(6'h00, v);
        chk(v[0] == 1'b0, "R11 run bit reads 0 after halt", v, 0);
        chk(qd_cnt == q0 && pkg_cnt == p0, "R11 no strobes after halt", qd_cnt - q0, 0);
        chk(xfer_seen == x0 && !mem_req, "R11 walk stopped", {31'b0, mem_req}, 0);
        wr(6'h00, 32'h1);
        wait_idle("R11 restart completes");
        repeat (2) @(negedge clk);
        chk(pkg_cnt - p0 == 2 && qd_cnt - q0 == 1, "R11 clean restart", pkg_cnt - p0, 2);
        chk(log_src[(xfer_seen - 1) % 64] == 32'h7100, "R11 restart follows links",
            log_src[(xfer_seen - 1) % 64], 32'h7100);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_chain3();
        t_decode();
        t_pause_pre();
        t_pause_mid();
        t_halt();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end
endmodule